// File: doc/BRIEF.md
# Hamming-Protected Cluster Status Link

This block moves a 9-bit cluster word (eight physics clusters and one test cluster) from one board to another over a 7-wire parallel backplane path. It splits each word into two consecutive clock slices. The first slice carries six data bits and a strobe. The second slice carries the remaining three data bits and four Hamming check bits. The receiver locks onto the strobe, so a transfer may begin on any cycle, even or odd. It rebuilds the 13-bit codeword, corrects any single flipped bit and presents the cluster word.

The block has two modes, selected by a level input. In trigger mode the sender takes one word per handshake. In busy mode the sender keeps re-sending the present busy word for as long as any bit is set, and sends nothing while all bits are clear. In busy mode the receiver shows the OR of the two newest decoded words. A cycle without a strobe, seen while the receiver waits for a frame, counts as an all-clear word. With this OR, a busy bit that changes during a transfer is still seen.

The sender and receiver sit in one top module. The link output and the link input are separate ports, so the board wiring, or a test harness, sits between them.

Top module: `cluster_link`

## Requirements
- R1: In the cycle after a word is accepted, `link_o[5:0]` carries word bits 5..0 and `link_o[6]` (the strobe) is 1.
- R2: In the cycle after the first slice, `link_o[2:0]` carries word bits 8..6 and `link_o[6:3]` carries check bits C3..C0. The codeword has positions 1..13. Check bit Ck sits at position 2^k. Data bits 0..8 fill positions 3,5,6,7,9,10,11,12,13 in that order. Ck gives even parity over every position whose index has bit k set.
- R3: In trigger mode a word is accepted on a rising edge when `tx_valid` and `tx_ready` are both 1. `tx_ready` is 0 in the next cycle and 1 again in the cycle after that, so at most one word is accepted every two cycles.
- R4: The receiver starts a frame on any cycle that shows a strobe. During the second slice it does not treat `link_i[6]` as a strobe, even when that bit is a check bit of value 1.
- R5: Take the last falling-edge sample before the accepting edge as cycle n. At the third rising edge after that sample, `rx_valid` pulses for one cycle, carrying the word on `rx_word`.
- R6: If any one of the 13 codeword bits is flipped on the link, the receiver still delivers the original word, and `rx_err` is 1 together with `rx_valid`. With no flipped bit, `rx_err` stays 0.
- R7: In trigger mode `rx_word` holds the last decoded word until the next `rx_valid`.
- R8: In busy mode `tx_valid` is ignored. The link stays all zero while `tx_word` is zero. While `tx_word` is nonzero, a new transfer starts every two cycles without a gap.
- R9: In busy mode `rx_word` is the OR of the two newest decoded words. Each idle cycle without a strobe counts as a decoded zero word, so `rx_word` clears after transfers stop.
- R10: After reset, `link_o` is 0, `tx_ready` is 1, and `rx_word`, `rx_valid` and `rx_err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bunch-crossing clock |
| rst | input | 1 | Synchronous active-high reset |
| busy_mode | input | 1 | 1 selects busy mode, 0 selects trigger mode |
| tx_valid | input | 1 | Word offered to the sender (trigger mode) |
| tx_word | input | 9 | Cluster word to send |
| tx_ready | output | 1 | Sender can accept a word this cycle |
| link_o | output | 7 | Sender side of the backplane wires |
| link_i | input | 7 | Receiver side of the backplane wires |
| rx_word | output | 9 | Decoded cluster word |
| rx_valid | output | 1 | One-cycle pulse when a word is decoded |
| rx_err | output | 1 | Nonzero syndrome on the word in this pulse |

## Verification
A receiver that loses framing shows up at once. It either pulses `rx_valid` with no word in flight, or it misses the pulse exactly two edges after the first slice, and the scoreboard matches pulses against the cycle of each accepted word. A wrong slice layout or a wrong check-bit equation shows on `link_o` during the two slices that follow acceptance, before the receiver is involved. A wrong correction shows in the same pulse as a mismatched word or a mismatched error flag. A stale history in busy mode shows as an OR value that is wrong in the first pulse after the word changes, or as a `rx_word` that stays set a few cycles after the link goes quiet.

// File: rtl/clink_pkg.sv
package clink_pkg;
    localparam int DATA_W = 9;
    localparam int CHK_W  = 4;
    localparam int CODE_W = DATA_W + CHK_W;
    localparam int LINK_W = 7;
    localparam int A_DATA = LINK_W - 1;
    localparam int B_DATA = DATA_W - A_DATA;

    typedef enum logic {PH_FIRST = 1'b0, PH_SECOND = 1'b1} phase_e;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              err;
    } dec_t;

    // Scatter data bits over the non-power-of-two codeword positions.
    function automatic logic [CODE_W:1] place_data(input logic [DATA_W-1:0] d);
        logic [CODE_W:1] c;
        int k;
        c = '0;
        k = 0;
        for (int p = 1; p <= CODE_W; p++) begin
            if ((p & (p - 1)) != 0) begin
                c[p] = d[k];
                k++;
            end
        end
        return c;
    endfunction

    function automatic logic [CHK_W-1:0] check_bits(input logic [DATA_W-1:0] d);
        logic [CODE_W:1] c;
        logic [CHK_W-1:0] h;
        c = place_data(d);
        h = '0;
        for (int b = 0; b < CHK_W; b++)
            for (int p = 1; p <= CODE_W; p++)
                if (((p >> b) & 1) == 1) h[b] = h[b] ^ c[p];
        return h;
    endfunction

    function automatic dec_t decode(input logic [DATA_W-1:0] d, input logic [CHK_W-1:0] h);
        logic [CODE_W:1] c;
        logic [CHK_W-1:0] syn;
        dec_t r;
        int k;
        c = place_data(d);
        for (int b = 0; b < CHK_W; b++) c[1 << b] = h[b];
        syn = '0;
        for (int p = 1; p <= CODE_W; p++)
            if (c[p]) syn = syn ^ CHK_W'(p);
        if (syn != '0 && int'(syn) <= CODE_W) c[syn] = ~c[syn];
        r.data = '0;
        k = 0;
        for (int p = 1; p <= CODE_W; p++) begin
            if ((p & (p - 1)) != 0) begin
                r.data[k] = c[p];
                k++;
            end
        end
        r.err = (syn != '0);
        return r;
    endfunction
endpackage

// File: rtl/clink_tx.sv
module clink_tx
    import clink_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              busy_mode,
    input  logic              tx_valid,
    input  logic [DATA_W-1:0] tx_word,
    output logic              tx_ready,
    output logic [LINK_W-1:0] link_o
);
    phase_e            phase_q;
    logic [LINK_W-1:0] link_q;
    logic [B_DATA-1:0] hi_q;
    logic [CHK_W-1:0]  chk_q;
    logic              start;

    assign start    = (phase_q == PH_FIRST) && (busy_mode ? (tx_word != '0) : tx_valid);
    assign tx_ready = (phase_q == PH_FIRST);
    assign link_o   = link_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_FIRST;
            link_q  <= '0;
            hi_q    <= '0;
            chk_q   <= '0;
        end else if (phase_q == PH_SECOND) begin
            link_q  <= {chk_q, hi_q};
            phase_q <= PH_FIRST;
        end else if (start) begin
            link_q  <= {1'b1, tx_word[A_DATA-1:0]};
            hi_q    <= tx_word[DATA_W-1:A_DATA];
            chk_q   <= check_bits(tx_word);
            phase_q <= PH_SECOND;
        end else begin
            link_q  <= '0;
        end
    end

    a_r3_ready_drop: assert property (@(posedge clk) disable iff (rst)
        (!busy_mode && tx_valid && tx_ready) |=> (!tx_ready && link_o[LINK_W-1]));
    a_r3_ready_return: assert property (@(posedge clk) disable iff (rst)
        !tx_ready |=> tx_ready);
    a_r8_quiet_link: assert property (@(posedge clk) disable iff (rst)
        (busy_mode && tx_ready && tx_word == '0) |=> (link_o == '0));
    a_r8_resend: assert property (@(posedge clk) disable iff (rst)
        (busy_mode && tx_ready && tx_word != '0) |=> link_o[LINK_W-1]);
endmodule

// File: rtl/clink_rx.sv
module clink_rx
    import clink_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              busy_mode,
    input  logic [LINK_W-1:0] link_i,
    output logic [DATA_W-1:0] rx_word,
    output logic              rx_valid,
    output logic              rx_err
);
    phase_e            ph_q;
    logic [A_DATA-1:0] lo_q;
    logic [DATA_W-1:0] last_q, prev_q;
    logic              valid_q, err_q;
    dec_t              dec;

    always_comb dec = decode({link_i[B_DATA-1:0], lo_q}, link_i[LINK_W-1:B_DATA]);

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q    <= PH_FIRST;
            lo_q    <= '0;
            last_q  <= '0;
            prev_q  <= '0;
            valid_q <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            valid_q <= 1'b0;
            err_q   <= 1'b0;
            if (ph_q == PH_SECOND) begin
                prev_q  <= last_q;
                last_q  <= dec.data;
                valid_q <= 1'b1;
                err_q   <= dec.err;
                ph_q    <= PH_FIRST;
            end else if (link_i[LINK_W-1]) begin
                lo_q    <= link_i[A_DATA-1:0];
                ph_q    <= PH_SECOND;
            end else if (busy_mode) begin
                prev_q  <= last_q;
                last_q  <= '0;
            end
        end
    end

    assign rx_word  = busy_mode ? (last_q | prev_q) : last_q;
    assign rx_valid = valid_q;
    assign rx_err   = err_q;

    a_r5_single_pulse: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> !rx_valid);
    a_r6_err_in_pulse: assert property (@(posedge clk) disable iff (rst)
        rx_err |-> rx_valid);
    a_r7_hold_word: assert property (@(posedge clk) disable iff (rst)
        (!busy_mode && $stable(busy_mode) && !rx_valid) |-> $stable(rx_word));
endmodule

// File: rtl/cluster_link.sv
module cluster_link
    import clink_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              busy_mode,
    input  logic              tx_valid,
    input  logic [DATA_W-1:0] tx_word,
    output logic              tx_ready,
    output logic [LINK_W-1:0] link_o,
    input  logic [LINK_W-1:0] link_i,
    output logic [DATA_W-1:0] rx_word,
    output logic              rx_valid,
    output logic              rx_err
);
    clink_tx u_tx (
        .clk       (clk),
        .rst       (rst),
        .busy_mode (busy_mode),
        .tx_valid  (tx_valid),
        .tx_word   (tx_word),
        .tx_ready  (tx_ready),
        .link_o    (link_o)
    );

    clink_rx u_rx (
        .clk       (clk),
        .rst       (rst),
        .busy_mode (busy_mode),
        .link_i    (link_i),
        .rx_word   (rx_word),
        .rx_valid  (rx_valid),
        .rx_err    (rx_err)
    );
endmodule

// File: tb/cluster_link_tb.sv
module cluster_link_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       busy_mode = 1'b0;
    logic       tx_valid = 1'b0;
    logic [8:0] tx_word = '0;
    logic       tx_ready;
    logic [6:0] link_o, link_i;
    logic [6:0] inj = '0;
    logic [8:0] rx_word;
    logic       rx_valid, rx_err;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    typedef struct {
        logic [8:0] d;
        logic       e;
        int         t;
    } exp_t;
    exp_t q[$];

    localparam int DPOS [9] = '{3, 5, 6, 7, 9, 10, 11, 12, 13};

    assign link_i = link_o ^ inj;

    cluster_link u_dut (
        .clk(clk), .rst(rst), .busy_mode(busy_mode), .tx_valid(tx_valid),
        .tx_word(tx_word), .tx_ready(tx_ready), .link_o(link_o), .link_i(link_i),
        .rx_word(rx_word), .rx_valid(rx_valid), .rx_err(rx_err)
    );

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [3:0] ref_chk(input logic [8:0] d);
        logic [3:0] h = '0;
        for (int i = 0; i < 9; i++)
            for (int b = 0; b < 4; b++)
                if (((DPOS[i] >> b) & 1) == 1) h[b] = h[b] ^ d[i];
        return h;
    endfunction

    // Trigger-mode driver: called at a negedge, returns at the negedge of slice 2.
    task automatic send(input logic [8:0] d, input int flip);
        exp_t x;
        tx_valid = 1'b1;
        tx_word  = d;
        check(tx_ready == 1'b1, "R3 ready before accept", 32'(tx_ready), 1);
        x.d = d;
        x.e = (flip < 14);
        x.t = cyc + 3;
        q.push_back(x);
        @(negedge clk);
        tx_valid = 1'b0;
        inj = (flip < 7) ? 7'(1 << flip) : '0;
        check(tx_ready == 1'b0, "R3 ready low after accept", 32'(tx_ready), 0);
        check(link_o == {1'b1, d[5:0]}, "R1 first slice", 32'(link_o), 32'({1'b1, d[5:0]}));
        @(negedge clk);
        inj = (flip >= 7 && flip < 14) ? 7'(1 << (flip - 7)) : '0;
        check(tx_ready == 1'b1, "R3 ready back", 32'(tx_ready), 1);
        check(link_o == {ref_chk(d), d[8:6]}, "R2 second slice", 32'(link_o), 32'({ref_chk(d), d[8:6]}));
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            inj = '0;
        end
    endtask

    // Scoreboard monitor for trigger mode (R5, R6).
    always @(negedge clk) begin
        if (!rst && rx_valid && !busy_mode) begin
            if (q.size() == 0) begin
                check(1'b0, "R4 unexpected rx_valid", 32'(rx_word), 0);
            end else begin
                exp_t x;
                x = q.pop_front();
                check(rx_word == x.d, "R6 decoded word", 32'(rx_word), 32'(x.d));
                check(rx_err == x.e, "R6 error flag", 32'(rx_err), 32'(x.e));
                check(cyc == x.t, "R5 latency", 32'(cyc), 32'(x.t));
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [8:0] a, b;
        bit found;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(link_o == '0, "R10 link", 32'(link_o), 0);
        check(tx_ready == 1'b1, "R10 ready", 32'(tx_ready), 1);
        check(rx_word == '0 && !rx_valid && !rx_err, "R10 rx", 32'({rx_err, rx_valid, rx_word}), 0);

        // Clean words, back to back and with odd/even gaps (R3, R4)
        send(9'h1A5, 99);
        send(9'h05A, 99);
        idle(1);
        send(9'h1FF, 99);
        idle(2);
        send(9'h001, 99);
        idle(3);
        // Word with C3 = 1 so link 7 is high in slice 2 (R4)
        for (int w = 1; w < 512; w++) begin
            if (ref_chk(9'(w))[3]) begin
                send(9'(w), 99);
                break;
            end
        end
        idle(4);
        // Single-bit flips on every codeword wire (R6)
        for (int f = 0; f < 14; f++) begin
            if (f != 6) begin
                send(9'h0C3 ^ 9'(f * 37), f);
                idle(f % 2);
            end
        end
        idle(5);
        check(q.size() == 0, "R5 all words delivered", 32'(q.size()), 0);
        // Hold between transfers (R7)
        a = rx_word;
        idle(4);
        check(rx_word == a && !rx_valid, "R7 hold", 32'(rx_word), 32'(a));

        // Busy mode: quiet link, valid ignored (R8), history clears (R9)
        @(negedge clk);
        busy_mode = 1'b1;
        tx_word = '0;
        tx_valid = 1'b1;
        found = 1'b0;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (link_o != '0) found = 1'b1;
        end
        check(!found, "R8 no strobe when clear", 32'(found), 0);
        check(rx_word == '0, "R9 idle clears", 32'(rx_word), 0);
        tx_valid = 1'b0;
        a = 9'h013;
        b = 9'h140;
        tx_word = a;
        @(negedge clk);
        found = 1'b0;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            if (link_o[6] == 1'b0 && link_o != {ref_chk(a), a[8:6]}) found = 1'b1;
        end
        check(!found, "R8 continuous resend", 32'(found), 0);
        check(rx_word == a, "R8 busy word", 32'(rx_word), 32'(a));
        tx_word = b;
        found = 1'b0;
        for (int i = 0; i < 12 && !found; i++) begin
            @(negedge clk);
            if (rx_valid && rx_word != a) begin
                found = 1'b1;
                check(rx_word == (a | b), "R9 OR of two words", 32'(rx_word), 32'(a | b));
            end
        end
        check(found, "R9 change seen", 32'(found), 1);
        found = 1'b0;
        for (int i = 0; i < 4 && !found; i++) begin
            @(negedge clk);
            if (rx_valid) begin
                found = 1'b1;
                check(rx_word == b, "R9 newest pair", 32'(rx_word), 32'(b));
            end
        end
        check(found, "R9 next pulse", 32'(found), 1);
        tx_word = '0;
        repeat (8) @(negedge clk);
        check(rx_word == '0, "R9 clears after stop", 32'(rx_word), 0);
        check(link_o == '0, "R8 quiet after stop", 32'(link_o), 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule